// File: doc/BRIEF.md
# DMA Page Register Bank and Physical Address Former

This block widens the 16-bit current address of a four-channel DMA engine into a 31-bit physical address. It holds two small banks of per-channel registers, an 8-bit page and a 7-bit high page, reached through eight byte ports each. The port-to-channel map is deliberately irregular, and four of the eight ports in each bank are dead.

For each transfer block it is handed, the block forms the start address and a byte-order flag. For an upward walk, the block starts `pos` bytes above the composed base. For a downward walk, the block ends just below `base - pos`. A verify transfer touches no memory, but it still reports its whole length as finished. The engine that owns arbitration and counting drives one access request per block and receives a registered strobe, an address, a length and a completion pulse one cycle later.

Top module: `dma_page_addr`

## Requirements
- R1: While reset is asserted, and after it is released, every page and high-page register reads 0, and the memory strobe and completion pulse are low.
- R2: Page port offset 3'd1 selects channel 2, 3'd2 selects channel 3, 3'd3 selects channel 1 and 3'd7 selects channel 0. A write through one of these offsets (bank select 0) is read back, combinationally, through the same offset.
- R3: Writes to offsets 0, 4, 5 and 6 of either bank change no register, and reads of those offsets return 0.
- R4: The high-page bank (bank select 1) uses the same offset-to-channel map. It keeps only the low 7 bits of a written byte and reads back with bit 7 as 0.
- R5: While `hi_page_en_i` is 0, high-page writes are dropped, high-page reads return 0 and the high page contributes zero to the address. Values stored earlier return once the input is 1 again.
- R6: The base address is `{high_page[6:0], page[7:0], cur[15:0]}` of the requested channel. With `acc_dec_i` = 0, the start address is base + pos, modulo 2^31, with carry into the page fields.
- R7: With `acc_dec_i` = 1, the start address is base − pos − len, modulo 2^31, and `xfer_rev_o` is 1 to mark reversed byte order. Otherwise `xfer_rev_o` is 0.
- R8: When `acc_kind_i` is 2'b00 (verify), `mem_req_o` stays low while `done_o` still pulses with `xfer_len_o` equal to the full requested length. Kinds 2'b01, 2'b10 and 2'b11 raise `mem_req_o` together with `done_o`.
- R9: `done_o` and `mem_req_o` are single-cycle pulses in the cycle after the edge that samples `acc_req_i`. Address, length and flag are registered on that edge, and they use the register values from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hi_page_en_i | input | 1 | Enables the high-page bank |
| reg_we_i | input | 1 | Register port write strobe |
| reg_sel_hi_i | input | 1 | 0 selects the page bank, 1 selects the high-page bank |
| reg_ofs_i | input | 3 | Port offset inside the bank |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data for the addressed port |
| acc_req_i | input | 1 | Access request, one cycle per block |
| acc_chan_i | input | 2 | Channel of the access |
| acc_cur_i | input | 16 | Current 16-bit address of the channel |
| acc_pos_i | input | 16 | Byte position of the block within the transfer |
| acc_len_i | input | 16 | Block length in bytes |
| acc_dec_i | input | 1 | 1 selects the downward address walk |
| acc_kind_i | input | 2 | Transfer kind; 2'b00 is verify |
| mem_req_o | output | 1 | Memory access strobe |
| done_o | output | 1 | Block completion pulse |
| mem_addr_o | output | 31 | Start physical address of the block |
| xfer_len_o | output | 16 | Length reported for the block |
| xfer_rev_o | output | 1 | Byte order of the block is reversed |

## Verification
A register stored under the wrong channel shows up at once, on the combinational read of the offset that should own it. It also shows in the top bits of the next access address for either channel involved. A bad dead-port decode or a bad enable gate shows as a nonzero read, or as a stray high page in an address, in the first cycle after the stray write. An error in the address arithmetic or in the verify decode appears exactly one clock after the request, so each request is compared one cycle later against a behavioural model of both banks. Carries across the page boundary and wraps below zero are driven on purpose.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
  localparam int unsigned CHAN_N = 4;
  localparam int unsigned CHAN_W = $clog2(CHAN_N);
  localparam int unsigned OFS_W  = 3;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_WRITE  = 2'b01,
    XF_READ   = 2'b10,
    XF_RSVD   = 2'b11
  } xfer_kind_e;

  typedef struct packed {
    logic              hit;
    logic [CHAN_W-1:0] chan;
  } port_dec_t;

  // irregular port map; unused offsets miss
  function automatic port_dec_t decode_port(input logic [OFS_W-1:0] ofs);
    port_dec_t d;
    d = '0;
    case (ofs)
      3'd1: d = '{hit: 1'b1, chan: 2'd2};
      3'd2: d = '{hit: 1'b1, chan: 2'd3};
      3'd3: d = '{hit: 1'b1, chan: 2'd1};
      3'd7: d = '{hit: 1'b1, chan: 2'd0};
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/dma_page_bank.sv
module dma_page_bank
  import dma_page_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [OFS_W-1:0]             ofs_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [REG_W-1:0]             rdata_o,
  output logic [CHAN_N-1:0][REG_W-1:0] regs_o
);
  port_dec_t dec;
  assign dec = decode_port(ofs_i);

  for (genvar g = 0; g < CHAN_N; g++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[g] <= '0;
      else if (wr_en_i && dec.hit && dec.chan == CHAN_W'(g))
        regs_o[g] <= wdata_i;
    end
  end

  assign rdata_o = dec.hit ? regs_o[dec.chan] : '0;
endmodule

// File: rtl/dma_addr_former.sv
module dma_addr_former
  import dma_page_pkg::*;
#(
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned HPAGE_W = 7,
  parameter int unsigned CUR_W   = 16,
  parameter int unsigned LEN_W   = 16,
  localparam int unsigned PHYS_W = HPAGE_W + PAGE_W + CUR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [HPAGE_W-1:0] hpage_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [CUR_W-1:0]   cur_i,
  input  logic [LEN_W-1:0]   pos_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               dec_i,
  input  xfer_kind_e         kind_i,
  output logic               mem_req_o,
  output logic               done_o,
  output logic [PHYS_W-1:0]  addr_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               rev_o
);
  logic [PHYS_W-1:0] base, pos_x, len_x, start;
  logic              is_verify;

  assign base      = {hpage_i, page_i, cur_i};
  assign pos_x     = PHYS_W'(pos_i);
  assign len_x     = PHYS_W'(len_i);
  // downward walk: block ends just below base - pos
  assign start     = dec_i ? (base - pos_x - len_x) : (base + pos_x);
  assign is_verify = (kind_i == XF_VERIFY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o <= 1'b0;
      done_o    <= 1'b0;
      addr_o    <= '0;
      len_o     <= '0;
      rev_o     <= 1'b0;
    end else begin
      done_o    <= req_i;
      mem_req_o <= req_i && !is_verify;
      if (req_i) begin
        addr_o <= start;
        len_o  <= len_i;
        rev_o  <= dec_i;
      end
    end
  end
endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr
  import dma_page_pkg::*;
#(
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned HPAGE_W = 7,
  parameter int unsigned CUR_W   = 16,
  parameter int unsigned LEN_W   = 16,
  localparam int unsigned PHYS_W = HPAGE_W + PAGE_W + CUR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hi_page_en_i,
  input  logic               reg_we_i,
  input  logic               reg_sel_hi_i,
  input  logic [2:0]         reg_ofs_i,
  input  logic [PAGE_W-1:0]  reg_wdata_i,
  output logic [PAGE_W-1:0]  reg_rdata_o,
  input  logic               acc_req_i,
  input  logic [1:0]         acc_chan_i,
  input  logic [CUR_W-1:0]   acc_cur_i,
  input  logic [LEN_W-1:0]   acc_pos_i,
  input  logic [LEN_W-1:0]   acc_len_i,
  input  logic               acc_dec_i,
  input  logic [1:0]         acc_kind_i,
  output logic               mem_req_o,
  output logic               done_o,
  output logic [PHYS_W-1:0]  mem_addr_o,
  output logic [LEN_W-1:0]   xfer_len_o,
  output logic               xfer_rev_o
);
  logic [CHAN_N-1:0][PAGE_W-1:0]  page_q;
  logic [CHAN_N-1:0][HPAGE_W-1:0] hpage_q;
  logic [PAGE_W-1:0]              page_rd;
  logic [HPAGE_W-1:0]             hpage_rd;
  logic                           page_we, hpage_we;
  logic [HPAGE_W-1:0]             hpage_sel;

  assign page_we  = reg_we_i && !reg_sel_hi_i;
  assign hpage_we = reg_we_i && reg_sel_hi_i && hi_page_en_i;

  dma_page_bank #(.REG_W(PAGE_W)) u_page (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (page_we),
    .ofs_i   (reg_ofs_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (page_rd),
    .regs_o  (page_q)
  );

  dma_page_bank #(.REG_W(HPAGE_W)) u_hpage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (hpage_we),
    .ofs_i   (reg_ofs_i),
    .wdata_i (reg_wdata_i[HPAGE_W-1:0]),
    .rdata_o (hpage_rd),
    .regs_o  (hpage_q)
  );

  always_comb begin
    if (!reg_sel_hi_i)     reg_rdata_o = page_rd;
    else if (hi_page_en_i) reg_rdata_o = PAGE_W'(hpage_rd);
    else                   reg_rdata_o = '0;
  end

  // disabled bank contributes no address bits
  assign hpage_sel = hi_page_en_i ? hpage_q[acc_chan_i] : '0;

  dma_addr_former #(
    .PAGE_W (PAGE_W),
    .HPAGE_W(HPAGE_W),
    .CUR_W  (CUR_W),
    .LEN_W  (LEN_W)
  ) u_former (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (acc_req_i),
    .hpage_i   (hpage_sel),
    .page_i    (page_q[acc_chan_i]),
    .cur_i     (acc_cur_i),
    .pos_i     (acc_pos_i),
    .len_i     (acc_len_i),
    .dec_i     (acc_dec_i),
    .kind_i    (xfer_kind_e'(acc_kind_i)),
    .mem_req_o (mem_req_o),
    .done_o    (done_o),
    .addr_o    (mem_addr_o),
    .len_o     (xfer_len_o),
    .rev_o     (xfer_rev_o)
  );
endmodule

// File: rtl/dma_page_addr_chk.sv
module dma_page_addr_chk #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned PHYS_W = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hi_page_en_i,
  input logic              reg_sel_hi_i,
  input logic [2:0]        reg_ofs_i,
  input logic [PAGE_W-1:0] reg_rdata_o,
  input logic              acc_req_i,
  input logic [LEN_W-1:0]  acc_len_i,
  input logic              acc_dec_i,
  input logic [1:0]        acc_kind_i,
  input logic              mem_req_o,
  input logic              done_o,
  input logic [LEN_W-1:0]  xfer_len_o,
  input logic              xfer_rev_o
);
  // R9
  done_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == $past(acc_req_i));
  // R8
  verify_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc_req_i && acc_kind_i == 2'b00) |-> !mem_req_o);
  // R8
  strobe_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> done_o);
  // R8
  full_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> xfer_len_o == $past(acc_len_i));
  // R7
  rev_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> xfer_rev_o == $past(acc_dec_i));
  // R3
  dead_port_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_ofs_i == 3'd0 || reg_ofs_i == 3'd4 || reg_ofs_i == 3'd5 || reg_ofs_i == 3'd6)
      |-> reg_rdata_o == '0);
  // R5
  hi_off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_hi_i && !hi_page_en_i) |-> reg_rdata_o == '0);
endmodule

bind dma_page_addr dma_page_addr_chk #(
  .PAGE_W(PAGE_W), .LEN_W(LEN_W), .PHYS_W(PHYS_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hi_page_en_i (hi_page_en_i),
  .reg_sel_hi_i (reg_sel_hi_i),
  .reg_ofs_i    (reg_ofs_i),
  .reg_rdata_o  (reg_rdata_o),
  .acc_req_i    (acc_req_i),
  .acc_len_i    (acc_len_i),
  .acc_dec_i    (acc_dec_i),
  .acc_kind_i   (acc_kind_i),
  .mem_req_o    (mem_req_o),
  .done_o       (done_o),
  .xfer_len_o   (xfer_len_o),
  .xfer_rev_o   (xfer_rev_o)
);

// File: tb/dma_page_addr_tb_top.sv
module dma_page_addr_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hi_page_en_i = 1'b0;
  logic        reg_we_i = 1'b0, reg_sel_hi_i = 1'b0;
  logic [2:0]  reg_ofs_i = '0;
  logic [7:0]  reg_wdata_i = '0, reg_rdata_o;
  logic        acc_req_i = 1'b0, acc_dec_i = 1'b0;
  logic [1:0]  acc_chan_i = '0, acc_kind_i = '0;
  logic [15:0] acc_cur_i = '0, acc_pos_i = '0, acc_len_i = '0;
  logic        mem_req_o, done_o, xfer_rev_o;
  logic [30:0] mem_addr_o;
  logic [15:0] xfer_len_o;

  always #2 clk_i = ~clk_i;

  dma_page_addr dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural model
  int  pg[4], hp[4];
  bit  e_req, e_done, e_rev;
  longint e_addr;
  int  e_len;

  function automatic int chan_of(int ofs);
    if (ofs == 7) return 0;
    if (ofs == 3) return 1;
    if (ofs == 1) return 2;
    if (ofs == 2) return 3;
    return -1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (pg[i]) begin pg[i] = 0; hp[i] = 0; end
      e_req = 0; e_done = 0; e_rev = 0; e_addr = 0; e_len = 0;
    end else begin
      e_done = acc_req_i;
      e_req  = acc_req_i && acc_kind_i != 2'b00;
      if (acc_req_i) begin
        longint b;
        b = (longint'(hi_page_en_i ? hp[acc_chan_i] : 0) << 24)
          | (longint'(pg[acc_chan_i]) << 16) | longint'(acc_cur_i);
        if (acc_dec_i) e_addr = (b - acc_pos_i - acc_len_i) & 64'h7FFF_FFFF;
        else           e_addr = (b + acc_pos_i) & 64'h7FFF_FFFF;
        e_len = acc_len_i;
        e_rev = acc_dec_i;
      end
      if (reg_we_i && chan_of(reg_ofs_i) >= 0) begin
        if (!reg_sel_hi_i) pg[chan_of(reg_ofs_i)] = reg_wdata_i;
        else if (hi_page_en_i) hp[chan_of(reg_ofs_i)] = reg_wdata_i & 8'h7F;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk_i) if (rst_ni && !finished) begin
    int c, er;
    string t;
    c = chan_of(reg_ofs_i);
    if (reg_sel_hi_i && !hi_page_en_i) begin er = 0; t = "R5"; end
    else if (c < 0) begin er = 0; t = "R3"; end
    else if (reg_sel_hi_i) begin er = hp[c]; t = "R4"; end
    else begin er = pg[c]; t = "R2"; end
    chk(t, 64'(reg_rdata_o), 64'(er));
    chk("R9 done", 64'(done_o), 64'(e_done));
    chk("R8 mem_req", 64'(mem_req_o), 64'(e_req));
    if (e_done) begin
      chk(e_rev ? "R7 addr" : "R6 addr", 64'(mem_addr_o), 64'(e_addr));
      chk("R8 len", 64'(xfer_len_o), 64'(e_len));
      chk("R7 rev", 64'(xfer_rev_o), 64'(e_rev));
    end
  end

  task automatic drive(bit we, bit hi, int ofs, int wd, bit req, int ch,
                       int cur, int pos, int len, bit dec, int kind);
    @(posedge clk_i); #1;
    reg_we_i = we; reg_sel_hi_i = hi; reg_ofs_i = 3'(ofs); reg_wdata_i = 8'(wd);
    acc_req_i = req; acc_chan_i = 2'(ch); acc_cur_i = 16'(cur);
    acc_pos_i = 16'(pos); acc_len_i = 16'(len); acc_dec_i = dec; acc_kind_i = 2'(kind);
  endtask
  task automatic wr(bit hi, int ofs, int d); drive(1, hi, ofs, d, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic rd(bit hi, int ofs);        drive(0, hi, ofs, 0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic acc(int ch, int cur, int pos, int len, bit dec, int kind);
    drive(0, 0, 0, 0, 1, ch, cur, pos, len, dec, kind);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 mem_req", 64'(mem_req_o), 0);
    chk("R1 done", 64'(done_o), 0);
    chk("R1 rdata", 64'(reg_rdata_o), 0);
    @(posedge clk_i); #1 rst_ni = 1; hi_page_en_i = 1;
    for (int o = 0; o < 8; o++) begin rd(0, o); rd(1, o); end  // R1 readback zeros
    // R2 R3 R4 fill both banks through every offset
    for (int o = 0; o < 8; o++) begin wr(0, o, 8'h10 + o); wr(1, o, 8'hC0 + o); end
    for (int o = 0; o < 8; o++) begin rd(0, o); rd(1, o); end
    // R6 increment, all kinds except verify
    for (int c = 0; c < 4; c++) acc(c, 16'h1234, 16'h20, 16'h40, 0, 1 + c % 3);
    acc(2, 16'hFFFF, 3, 8, 0, 2);           // carry into page
    // R7 decrement and wrap below zero
    acc(0, 16'h0100, 16'h10, 16'h20, 1, 1);
    wr(0, 3, 0); wr(1, 3, 0);
    acc(1, 5, 3, 10, 1, 2);
    // R8 verify in both directions
    acc(3, 16'h0800, 4, 16'hFFFF, 0, 0);
    acc(3, 16'h0800, 4, 16'h0010, 1, 0);
    // R9 write and access in one cycle uses old page
    drive(1, 0, 7, 8'h5A, 1, 0, 16'h0042, 0, 1, 0, 1);
    acc(0, 16'h0042, 0, 1, 0, 1);
    // R5 disabled high bank
    @(posedge clk_i); #1 hi_page_en_i = 0;
    wr(1, 1, 8'h33); rd(1, 1); rd(1, 7);
    acc(2, 16'h0, 0, 4, 0, 1);
    @(posedge clk_i); #1 hi_page_en_i = 1;
    rd(1, 1); acc(2, 16'h0, 0, 4, 0, 1);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) begin @(posedge clk_i); #1 hi_page_en_i = $urandom_range(0, 1); end
      drive($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7),
            $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 3),
            $urandom_range(0, 65535), $urandom_range(0, 65535),
            $urandom_range(0, 65535), $urandom_range(0, 1), $urandom_range(0, 3));
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1 finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule